// File: doc/BRIEF.md
# Strobe Activity Watchdog

This block checks that a processor keeps toggling a strobe line. It counts timebase ticks. Each high-to-low transition of the strobe, once synchronized into the block clock, restarts the count. If the count reaches the window length with no such transition, the block drives its active-low status output low for a fixed number of ticks. It then opens a new window. The status line can be wired back to a pushbutton-reset input elsewhere, so that a stalled processor forces a system reset.

The supervisor's reset-active level freezes the block. While that level is high, the counter stays at zero and the status output stays high. A new window starts only when the level drops. Window and pulse lengths are parameters, counted in ticks of the timebase input. The synchronizer depth is also a parameter.

Top module: `strobe_watchdog`

## Requirements
- R1: After block reset (`rst_n` low), `wd_status_n_o` is 1.
- R2: While `sys_rst_i` is 1, `wd_status_n_o` is 1 and the window count is held at zero. After `sys_rst_i` falls, a full window of `TIMEOUT_TICKS` ticks is needed before a timeout.
- R3: With no strobe falling edge, `wd_status_n_o` goes to 0 on the clock edge that takes the `TIMEOUT_TICKS`-th tick after the window opened. Only cycles with `tick_i` = 1 advance the count.
- R4: Once low, `wd_status_n_o` stays 0 for exactly `PULSE_TICKS` ticks and returns to 1 on the edge that takes the last of them.
- R5: A falling edge on `strobe_i` restarts the window from zero. With `tick_i` held at 1, a fall applied before edge k gives the timeout at edge k + `SYNC_STAGES` + `TIMEOUT_TICKS`.
- R6: A rising edge on `strobe_i`, or a level held constant (high or low), does not restart the window.
- R7: Strobe edges during the low pulse neither shorten nor extend it.
- R8: When the pulse ends, a new window of `TIMEOUT_TICKS` ticks starts at once.
- R9: If a synchronized falling edge and the tick that would end the window arrive in the same cycle, the restart wins and no pulse is produced.
- R10: The strobe passes through `SYNC_STAGES` flip-flops and one edge-detect stage. A single falling transition causes exactly one restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| tick_i | input | 1 | Timebase tick, one clock wide, advances the counters |
| sys_rst_i | input | 1 | Supervisor reset-active level, high freezes the watchdog |
| strobe_i | input | 1 | Raw asynchronous processor strobe |
| wd_status_n_o | output | 1 | Watchdog status, low during the timeout pulse |

## Verification
A synchronized strobe fall and the tick that ends the window can land in the same cycle. Here the restart must win. The bench provokes this on purpose: with ticks held at 1, it drops the strobe exactly `SYNC_STAGES` edges before the final tick. It then expects the status line to stay high for a further full window. A cycle-level reference model in the bench also meets this collision by chance during the random phase. It judges every cycle, including cycles where a supervisor reset lands on a timeout or on a pulse end.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic {
        WD_WATCH = 1'b0,
        WD_PULSE = 1'b1
    } wd_state_e;
endpackage

// File: rtl/swd_edge_sync.sv
module swd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    localparam int W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [W-1:0] pipe;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.pipe = {r_q.pipe[W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pipe: '1};
        else        r_q <= r_d;
    end

    // previous synchronized level high, current low -> one-cycle fall pulse (R10)
    assign fall_o = r_q.pipe[W-1] & ~r_q.pipe[W-2];

endmodule

// File: rtl/swd_timer.sv
module swd_timer
    import swd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000,
    parameter int PULSE_TICKS   = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic fall_i,
    output logic status_n_o
);
    localparam int CNT_MAX = (TIMEOUT_TICKS > PULSE_TICKS) ? TIMEOUT_TICKS : PULSE_TICKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] WIN_LAST   = CW'(TIMEOUT_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

    typedef struct packed {
        wd_state_e     state;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hold_i) begin
            r_d.state = WD_WATCH;
            r_d.cnt   = '0;
        end else if (r_q.state == WD_WATCH) begin
            if (fall_i) begin
                r_d.cnt = '0;
            end else if (tick_i) begin
                if (r_q.cnt == WIN_LAST) begin
                    r_d.state = WD_PULSE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end else if (tick_i) begin
            if (r_q.cnt == PULSE_LAST) begin
                r_d.state = WD_WATCH;
                r_d.cnt   = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: WD_WATCH, cnt: '0};
        else        r_q <= r_d;
    end

    assign status_n_o = (r_q.state != WD_PULSE);

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> status_n_o) else $error("hold high");                          // R2
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (r_q.cnt == '0)) else $error("hold frozen");                   // R2
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_n_o) |-> ($past(tick_i) && !$past(hold_i) && !$past(fall_i)))
        else $error("pulse cause");                                               // R3
    AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_n_o && !tick_i && !hold_i) |=> !status_n_o) else $error("pulse steady"); // R7
    AST_FALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (status_n_o && fall_i && !hold_i) |=> (status_n_o && r_q.cnt == '0))
        else $error("fall restart");                                              // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        status_n_o |-> (r_q.cnt <= WIN_LAST)) else $error("cnt bound");           // R3

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
    parameter int TIMEOUT_TICKS = 1000,
    parameter int PULSE_TICKS   = 150,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sys_rst_i,
    input  logic strobe_i,
    output logic wd_status_n_o
);
    logic strobe_fall;

    swd_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(strobe_i),
        .fall_o (strobe_fall)
    );

    swd_timer #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .hold_i    (sys_rst_i),
        .fall_i    (strobe_fall),
        .status_n_o(wd_status_n_o)
    );

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_fall |=> !strobe_fall) else $error("fall single");   // R10

endmodule

// File: tb/strobe_watchdog_tb.sv
module strobe_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 20;
    localparam int PW = 8;
    localparam int SS = 2;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b1;
    logic sys_rst_i = 1'b1;
    logic strobe_i = 1'b1;
    logic wd_status_n_o;

    int vectors = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 1'b0;

    // reference model state
    logic [SS:0] m_pipe = '1;
    bit m_pulse = 1'b0;
    int m_cnt = 0;

    strobe_watchdog #(.TIMEOUT_TICKS(TO), .PULSE_TICKS(PW), .SYNC_STAGES(SS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sys_rst_i(sys_rst_i),
        .strobe_i(strobe_i), .wd_status_n_o(wd_status_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_fall(logic [SS:0] p);
        return p[SS] & ~p[SS-1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe = '1; m_pulse = 1'b0; m_cnt = 0;
        end else begin
            bit f;
            f = model_fall(m_pipe);
            if (sys_rst_i) begin
                m_pulse = 1'b0; m_cnt = 0;
            end else if (!m_pulse) begin
                if (f) m_cnt = 0;
                else if (tick_i) begin
                    if (m_cnt == TO-1) begin m_pulse = 1'b1; m_cnt = 0; end
                    else m_cnt++;
                end
            end else if (tick_i) begin
                if (m_cnt == PW-1) begin m_pulse = 1'b0; m_cnt = 0; end
                else m_cnt++;
            end
            m_pipe = {m_pipe[SS-1:0], strobe_i};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (wd_status_n_o !== ~m_pulse) begin
                errors++;
                $display("FAIL %s model: status=%b expected=%b at %0t", phase, wd_status_n_o, ~m_pulse, $time);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // count edges until status reaches target level; optionally toggle strobe each cycle
    task automatic edges_until(logic target, bit toggle, output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            if (toggle) strobe_i = ~strobe_i;
        end while (wd_status_n_o !== target && n < 1000);
    endtask

    task automatic hold_sys(int cycles);
        sys_rst_i = 1'b1;
        repeat (cycles) @(negedge clk);
        sys_rst_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        check("R1", wd_status_n_o, 1);

        phase = "R2";
        repeat (TO + 10) @(negedge clk);
        check("R2", wd_status_n_o, 1);

        phase = "R3";
        sys_rst_i = 1'b0;
        edges_until(1'b0, 1'b0, n);
        check("R3", n, TO);

        phase = "R4";
        edges_until(1'b1, 1'b0, n);
        check("R4", n, PW);

        phase = "R8";
        edges_until(1'b0, 1'b0, n);
        check("R8", n, TO);

        phase = "R7";
        edges_until(1'b1, 1'b1, n);
        check("R7", n, PW);

        // R6: rising edge right after pulse, then constant high
        phase = "R6";
        strobe_i = 1'b0;
        hold_sys(4);
        strobe_i = 1'b1;
        edges_until(1'b0, 1'b0, n);
        check("R6", n, TO);
        edges_until(1'b1, 1'b0, n);
        // R6: constant low level
        strobe_i = 1'b0;
        hold_sys(4);
        edges_until(1'b0, 1'b0, n);
        check("R6", n, TO);

        // R5 / R10: single fall after 10 ticks
        phase = "R5";
        strobe_i = 1'b1;
        hold_sys(4);
        repeat (10) @(negedge clk);
        strobe_i = 1'b0;
        edges_until(1'b0, 1'b0, n);
        check("R5", n, TO + SS + 1);
        check("R10", n, TO + SS + 1);

        // R9: synchronized fall collides with final window tick
        phase = "R9";
        strobe_i = 1'b1;
        hold_sys(4);
        repeat (TO - SS - 1) @(negedge clk);
        strobe_i = 1'b0;
        edges_until(1'b0, 1'b0, n);
        check("R9", n, TO + SS + 1);

        // random phase against reference model
        phase = "R5";
        strobe_i = 1'b1;
        hold_sys(4);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick_i = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 24) == 0) strobe_i = ~strobe_i;
            if ($urandom_range(0, 399) == 0) sys_rst_i = 1'b1;
            else if (sys_rst_i && $urandom_range(0, 3) == 0) sys_rst_i = 1'b0;
        end
        @(negedge clk);
        finish_run();
    end
endmodule